// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small synchronous Moore controller for a single-slot coin acceptor that takes two coin sizes, a small coin worth 5 units and a large coin worth 10 units. It keeps the credit deposited so far as one of a few discrete levels. When the credit reaches the 15-unit price it raises a release strobe to the dispensing mechanism. No change is given. Any overpayment, such as two large coins, is kept, and the credit saturates at the price level.

The coin sensors deliver one single-cycle pulse per coin. The next-credit logic, the state register and the registered release output sit in separate processes. The release strobe depends on the credit level alone, so a coin pulse never reaches it combinationally. After a sale the controller returns to zero credit on the following clock and ignores whatever coin pulse arrives in that cycle.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the credit at 0 and holds `vend_open` low in the cycle after the reset edge. Coins deposited before a reset do not count towards a sale.
- R2: A small-coin pulse alone, with credit below the price, raises the credit by 5 units at that clock edge. Three small coins in a row complete a sale.
- R3: A large-coin pulse alone, with credit below the price, raises the credit by 10 units. A large coin followed by a small coin, or a small coin followed by a large coin, completes a sale.
- R4: Credit that would pass 15 units saturates at 15 and completes the sale. Two large coins give exactly one release and no leftover credit.
- R5: In a cycle with no coin pulse, the credit holds its value.
- R6: When both coin pulses arrive in the same cycle, the controller ignores both and holds its credit.
- R7: `vend_open` is high only while the credit is at 15 units. It is high for exactly one cycle per sale, starting in the cycle after the edge that completed the payment.
- R8: From the 15-unit level the credit returns to 0 on the next clock whatever the coin inputs are. A coin arriving in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_small | input | 1 | One-cycle pulse per 5-unit coin |
| coin_large | input | 1 | One-cycle pulse per 10-unit coin |
| vend_open | output | 1 | Registered release strobe, one cycle per sale |

## Verification
The bench builds the block with its default values: a 5-unit small coin, a 10-unit large coin and a 15-unit price. With these values the credit has four levels, and a large coin is worth two steps, so a 10+10 deposit passes the price by one step. The saturation path, the discard of a coin that arrives during the release cycle, and a simultaneous pulse on both inputs at every credit level below the price can all be reached within a few cycles. A long pseudo-random coin stream mixes these cases with reset in the middle of a payment.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Credit level after adding a coin step, clamped at the price level.
  function automatic int unsigned credit_add(input int unsigned level,
                                             input int unsigned step,
                                             input int unsigned top);
    int unsigned sum;
    sum = level + step;
    return (sum > top) ? top : sum;
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
  parameter int LARGE_STEPS = 2,
  parameter int STEP_W      = 2
) (
  input  logic              coin_small,
  input  logic              coin_large,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] SMALL_S = STEP_W'(1);
  localparam logic [STEP_W-1:0] LARGE_S = STEP_W'(LARGE_STEPS);

  // Exactly one coin counts; both together or none give no step.
  always_comb begin
    step = '0;
    if (coin_small && !coin_large)      step = SMALL_S;
    else if (coin_large && !coin_small) step = LARGE_S;
  end
endmodule

// File: rtl/vend_next_level.sv
module vend_next_level
  import vend_pkg::*;
#(
  parameter int ST_W   = 2,
  parameter int STEP_W = 2,
  parameter int TOP    = 3
) (
  input  logic [ST_W-1:0]   level,
  input  logic [STEP_W-1:0] step,
  output logic [ST_W-1:0]   level_nxt
);
  localparam logic [ST_W-1:0] TOP_L = ST_W'(TOP);

  always_comb begin
    if (level == TOP_L) level_nxt = '0;
    else level_nxt = ST_W'(credit_add(int'(level), int'(step), TOP));
  end
endmodule

// File: rtl/vend_release_reg.sv
module vend_release_reg #(
  parameter int ST_W = 2,
  parameter int TOP  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] level_nxt,
  output logic            vend_open
);
  localparam logic [ST_W-1:0] TOP_L = ST_W'(TOP);

  // Moore output, registered: high exactly while the credit register holds TOP.
  always_ff @(posedge clk) begin
    if (rst) vend_open <= 1'b0;
    else     vend_open <= (level_nxt == TOP_L);
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int UNIT_SMALL = 5,
  parameter int UNIT_LARGE = 10,
  parameter int PRICE      = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_small,
  input  logic coin_large,
  output logic vend_open
);
  localparam int LARGE_STEPS = UNIT_LARGE / UNIT_SMALL;
  localparam int TOP         = (PRICE + UNIT_SMALL - 1) / UNIT_SMALL;
  localparam int LEVELS      = TOP + 1;
  localparam int ST_W        = (LEVELS > 2) ? $clog2(LEVELS) : 1;
  localparam int STEP_W      = $clog2(LARGE_STEPS + 1);

  logic [STEP_W-1:0] step;
  logic [ST_W-1:0]   level_q;
  logic [ST_W-1:0]   level_nxt;

  vend_coin_decode #(.LARGE_STEPS(LARGE_STEPS), .STEP_W(STEP_W)) u_dec (
    .coin_small(coin_small),
    .coin_large(coin_large),
    .step      (step)
  );

  vend_next_level #(.ST_W(ST_W), .STEP_W(STEP_W), .TOP(TOP)) u_nxt (
    .level    (level_q),
    .step     (step),
    .level_nxt(level_nxt)
  );

  // Credit state register: 0=00, 5=01, 10=10, 15=11 with default values.
  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_nxt;
  end

  vend_release_reg #(.ST_W(ST_W), .TOP(TOP)) u_rel (
    .clk      (clk),
    .rst      (rst),
    .level_nxt(level_nxt),
    .vend_open(vend_open)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int ST_W  = 2,
  parameter int TOP   = 3,
  parameter int LSTEP = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            coin_small,
  input logic            coin_large,
  input logic            vend_open,
  input logic [ST_W-1:0] level_q
);
  localparam logic [ST_W-1:0] TOP_L = ST_W'(TOP);
  localparam logic [ST_W-1:0] NEAR  = ST_W'(TOP - LSTEP);
  localparam logic [ST_W-1:0] LS    = ST_W'(LSTEP);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!vend_open && level_q == '0));

  assert_small_step_R2: assert property (@(posedge clk) disable iff (rst)
    (coin_small && !coin_large && level_q != TOP_L)
      |=> level_q == ST_W'($past(level_q) + 1'b1));

  assert_large_from_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (coin_large && !coin_small && level_q == '0) |=> level_q == LS);

  assert_large_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (coin_large && !coin_small && level_q != TOP_L && level_q >= NEAR) |=> vend_open);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!coin_small && !coin_large && level_q != TOP_L) |=> $stable(level_q));

  assert_both_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (coin_small && coin_large && level_q != TOP_L) |=> $stable(level_q));

  assert_open_at_top_R7: assert property (@(posedge clk) disable iff (rst)
    vend_open |-> level_q == TOP_L);

  assert_open_single_R7: assert property (@(posedge clk) disable iff (rst)
    vend_open |=> !vend_open);

  assert_return_zero_R8: assert property (@(posedge clk) disable iff (rst)
    vend_open |=> level_q == '0);
endmodule

bind vend_ctrl vend_ctrl_chk #(.ST_W(ST_W), .TOP(TOP), .LSTEP(LARGE_STEPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .coin_small(coin_small),
  .coin_large(coin_large),
  .vend_open (vend_open),
  .level_q   (level_q)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic coin_small = 1'b0;
  logic coin_large = 1'b0;
  logic vend_open;

  int total = 0;
  int bad = 0;
  int credit = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vend_ctrl u0 (
    .clk(clk), .rst(rst), .coin_small(coin_small),
    .coin_large(coin_large), .vend_open(vend_open)
  );

  task automatic check(input string tag);
    logic exp;
    exp = (credit == 15);
    total++;
    if (vend_open !== exp) begin
      bad++;
      $display("FAIL %s: vend_open=%b expected=%b (credit %0d)", tag, vend_open, exp, credit);
    end
  endtask

  // Called at a negedge; one clock with the given coins, then check at the next negedge.
  task automatic coin(input logic s, input logic l, input string tag);
    coin_small = s; coin_large = l;
    @(posedge clk);
    if (credit >= 15)   credit = 0;
    else if (s && !l)   credit = (credit + 5 > 15) ? 15 : credit + 5;
    else if (l && !s)   credit = (credit + 10 > 15) ? 15 : credit + 10;
    @(negedge clk);
    coin_small = 1'b0; coin_large = 1'b0;
    check(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk);
    credit = 0;
    @(negedge clk);
    rst = 1'b0;
    check(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset("R1 reset state");
    // R2: three small coins
    coin(1,0,"R2 5"); coin(1,0,"R2 10"); coin(1,0,"R2 15 opens");
    coin(0,0,"R8 return after sale");
    // R3: large then small, small then large
    coin(0,1,"R3 10"); coin(1,0,"R3 10+5 opens"); coin(0,0,"R7 one cycle");
    coin(1,0,"R3 5"); coin(0,1,"R3 5+10 opens"); coin(0,0,"R7 one cycle");
    // R4: overpayment saturates
    coin(0,1,"R4 10"); coin(0,1,"R4 10+10 opens"); coin(0,0,"R4 no leftover");
    coin(1,0,"R4 leftover check"); coin(1,0,"R4 leftover check");
    coin(1,0,"R4 third small opens"); coin(0,0,"R7 idle");
    // R5: hold with idle cycles
    coin(1,0,"R5 5");
    for (int i = 0; i < 4; i++) coin(0,0,"R5 idle hold");
    coin(0,1,"R5 held 5+10 opens"); coin(0,0,"R7 idle");
    // R6: both coins ignored
    coin(0,1,"R6 10"); coin(1,1,"R6 both ignored"); coin(1,1,"R6 both ignored");
    coin(1,0,"R6 held 10+5 opens"); coin(0,0,"R7 idle");
    coin(1,1,"R6 both at zero"); coin(0,1,"R6 zero kept"); coin(0,0,"R6 no open");
    coin(1,0,"R6 opens"); coin(0,0,"R7 idle");
    // R8: coin during release cycle discarded
    coin(0,1,"R8 10"); coin(0,1,"R8 opens"); coin(0,1,"R8 coin discarded");
    coin(1,0,"R8 5"); coin(1,0,"R8 10"); coin(1,0,"R8 opens");
    coin(0,0,"R8 idle");
    // R1: reset in the middle of a payment
    coin(0,1,"R1 10"); do_reset("R1 mid reset");
    coin(1,0,"R1 credit cleared"); coin(1,0,"R1 credit cleared");
    coin(1,0,"R1 opens after 15 new"); coin(0,0,"R7 idle");
    // R7: pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:0] == 8'h5A) do_reset("R1 random reset");
      else coin(lfsr[3] & lfsr[0], lfsr[5] & ~lfsr[1], "R7 random stream");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule